// File: doc/BRIEF.md
# Cascadable Bidirectional Line-Data Loader

This block gathers one display line of 6-bit gray-scale codes for a column driver that sits in a chain of identical drivers. A line holds 384 codes. The codes arrive six at a time on a 36-bit bus, one word per clock, so a line takes 64 words. The six groups in a word cover two RGB pixels. Group `g` sits in bits `6g+5:6g`, and bit 0 of each code is its LSB.

Loading begins when a start pulse is seen on the input end of the chain. The direction select decides which end is the input. When it is high, the right-end start pin is the input, words fill the line from output 1 upward, and the left-end start pin drives the cascade pulse. When it is low, these roles are swapped.

After 64 words the block sends a one-clock pulse from its far end, which starts the next driver in the chain. After 66 clocks it stops loading on its own. It then ignores the chain until a rising edge on the strobe returns it to idle. Each half of the bus has its own control that bit-inverts that half as the word is stored. The line register is presented in parallel for the conversion stages that follow.

Top module: `line_loader`

## Requirements
- R1: While `rst_n` is low at a rising edge, both cascade outputs are 0 after that edge, and the block returns to idle. The line register has no reset value.
- R2: A start is accepted at a rising edge where the block is idle, the selected start input is high, and that input was low at the previous edge. The word on `data_i` at that same edge is stored as word 0. Keeping the start high for more clocks, or raising it again while loading, has no effect.
- R3: With `shift_right_i`=1, only `rend_start_i` can start a line. Word k (k = 0 to 63) is stored at codes 6k to 6k+5, and group g of the word lands at code 6k+g. Code n occupies `line_o[6n+5:6n]`.
- R4: With `shift_right_i`=0, only `lend_start_i` can start a line. Word k is stored at codes 6(63-k) to 6(63-k)+5, with group g at code 6(63-k)+g. The direction is taken at start acceptance.
- R5: Counting the start edge as clock 1, the cascade output at the far end is high for exactly the cycle after clock 64. The far end is `lend_start_o` for right shift and `rend_start_o` for left shift. The other cascade output stays 0.
- R6: After clock 66 no word is stored and `line_o` holds its value. A start pulse is ignored until a strobe rising edge.
- R7: When `inv_lo_i` is high, bits 17:0 (groups 0 to 2) of the word are stored inverted. When `inv_hi_i` is high, bits 35:18 (groups 3 to 5) are stored inverted. Both controls are sampled with each word.
- R8: At a rising edge where `strb_i` is high and was low at the previous edge, no word is stored and the block returns to idle. No cascade pulse follows, and the next start pulse is accepted.
- R9: A reset in the middle of a line stops loading, and it leaves the codes already stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_right_i | input | 1 | 1: right shift; 0: left shift |
| rend_start_i | input | 1 | Right-end start input (used in right shift) |
| rend_start_o | output | 1 | Right-end cascade output (driven in left shift) |
| lend_start_i | input | 1 | Left-end start input (used in left shift) |
| lend_start_o | output | 1 | Left-end cascade output (driven in right shift) |
| data_i | input | 36 | Six 6-bit codes, group g in bits 6g+5:6g |
| inv_lo_i | input | 1 | Invert bits 17:0 while storing |
| inv_hi_i | input | 1 | Invert bits 35:18 while storing |
| strb_i | input | 1 | Strobe; its rising edge clears the loading state |
| line_o | output | 2304 | Line register, code n in bits 6n+5:6n |

## Verification
A word presented before the start edge, or before any later edge of a run, appears in `line_o` directly after that edge, because the only register on the path is the line register. The cascade pulse passes through one register and is visible only in the cycle that follows the 64th edge of the run. The halt takes effect after the 66th edge. Inputs change on the falling clock edge, and the outputs are sampled on the falling edge. The scoreboard therefore records the cycle count of the start edge plus 64 as the single cycle in which a cascade pulse is due. Any pulse in another cycle, or on the other pin, is reported. The line is compared with the bench's own model after each run.

// File: rtl/line_loader_pkg.sv
// Shared types for the line loader.
package line_loader_pkg;
    // Token controller state: waiting for a start, loading, or halted after a run.
    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_RUN  = 2'd1,
        LD_HALT = 2'd2
    } ld_state_e;
endpackage

// File: rtl/ldr_token_ctrl.sv
// Start-token controller.
// Detects an accepted start pulse and counts the clocks of a run.
// Produces the write enable and the word index for each clock.
// Raises the cascade pulse after clock CASC_CLK and halts after clock HALT_CLKS.
// Assumes WORDS <= CASC_CLK < HALT_CLKS. A strobe rising edge overrides everything except reset.
module ldr_token_ctrl
    import line_loader_pkg::*;
#(
    parameter int WORDS     = 64,
    parameter int CASC_CLK  = 64,
    parameter int HALT_CLKS = 66,
    localparam int IDX_W    = $clog2(WORDS),
    localparam int CNT_W    = $clog2(HALT_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_i,
    input  logic             start_i,
    input  logic             strb_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic             wr_dir_o,
    output logic             casc_o,
    output logic             casc_dir_o,
    output ld_state_e        state_o
);
    ld_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start_prev_q;
    logic             strb_prev_q;
    logic             dir_q;
    logic             casc_q;
    logic             strb_rise;
    logic             accept;

    // Decode the strobe edge, the start acceptance and this clock's write.
    always_comb begin
        strb_rise = strb_i & ~strb_prev_q;
        accept    = (state_q == LD_IDLE) & start_i & ~start_prev_q & ~strb_rise;
        wr_en_o   = rst_n & (accept | ((state_q == LD_RUN) & (cnt_q < CNT_W'(WORDS)) & ~strb_rise));
        wr_idx_o  = accept ? '0 : cnt_q[IDX_W-1:0];
        wr_dir_o  = accept ? dir_i : dir_q;
    end

    // Strobe history for edge detection, sampled every clock.
    always_ff @(posedge clk) begin
        strb_prev_q <= strb_i;
    end

    // Run state, clock counter, latched direction and cascade pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= LD_IDLE;
            cnt_q        <= '0;
            start_prev_q <= 1'b0;
            dir_q        <= 1'b0;
            casc_q       <= 1'b0;
        end else begin
            start_prev_q <= start_i;
            casc_q       <= 1'b0;
            if (strb_rise) begin
                state_q <= LD_IDLE;
                cnt_q   <= '0;
            end else begin
                case (state_q)
                    LD_IDLE: begin
                        if (accept) begin
                            state_q <= LD_RUN;
                            cnt_q   <= CNT_W'(1);
                            dir_q   <= dir_i;
                        end
                    end
                    LD_RUN: begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_W'(CASC_CLK - 1)) casc_q <= 1'b1;
                        if (cnt_q == CNT_W'(HALT_CLKS - 1)) state_q <= LD_HALT;
                    end
                    default: begin
                        state_q <= LD_HALT;
                    end
                endcase
            end
        end
    end

    assign casc_o     = casc_q;
    assign casc_dir_o = dir_q;
    assign state_o    = state_q;
endmodule

// File: rtl/ldr_word_xform.sv
// Per-half inversion of the incoming word.
// Groups below GROUPS/2 follow inv_lo_i, and the rest follow inv_hi_i. Purely combinational.
module ldr_word_xform #(
    parameter int CODE_W   = 6,
    parameter int GROUPS   = 6,
    localparam int WORD_W  = CODE_W * GROUPS,
    localparam int LO_GRPS = GROUPS / 2
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              inv_lo_i,
    input  logic              inv_hi_i,
    output logic [WORD_W-1:0] word_o
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic inv;
        // Choose this group's inversion control and apply it.
        always_comb begin
            inv = (g < LO_GRPS) ? inv_lo_i : inv_hi_i;
            word_o[g*CODE_W +: CODE_W] = word_i[g*CODE_W +: CODE_W] ^ {CODE_W{inv}};
        end
    end
endmodule

// File: rtl/ldr_line_store.sv
// Line register, organised as WORDS slots of one word each.
// One slot is written per enabled clock. There is no reset: contents persist until they are overwritten.
module ldr_line_store #(
    parameter int WORD_W  = 36,
    parameter int WORDS   = 64,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int LINE_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_slot_i,
    input  logic [WORD_W-1:0] wr_word_i,
    output logic [LINE_W-1:0] line_o
);
    for (genvar s = 0; s < WORDS; s++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        // Capture the word when this slot is addressed.
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_slot_i == IDX_W'(s))) slot_q <= wr_word_i;
        end
        assign line_o[s*WORD_W +: WORD_W] = slot_q;
    end
endmodule

// File: rtl/line_loader.sv
// Cascadable bidirectional line-data loader.
// Picks the start input from the direction, maps word index to slot, inverts each half of the word
// on request, and drives the cascade pulse out of the far end. Reset is synchronous and active low.
module line_loader
    import line_loader_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int GROUPS    = 6,
    parameter int WORDS     = 64,
    parameter int CASC_CLK  = 64,
    parameter int HALT_CLKS = 66,
    localparam int WORD_W   = CODE_W * GROUPS,
    localparam int LINE_W   = WORD_W * WORDS,
    localparam int IDX_W    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_right_i,
    input  logic              rend_start_i,
    output logic              rend_start_o,
    input  logic              lend_start_i,
    output logic              lend_start_o,
    input  logic [WORD_W-1:0] data_i,
    input  logic              inv_lo_i,
    input  logic              inv_hi_i,
    input  logic              strb_i,
    output logic [LINE_W-1:0] line_o
);
    logic              start_sel;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic              wr_dir;
    logic              casc;
    logic              casc_dir;
    ld_state_e         run_state;
    logic [IDX_W-1:0]  wr_slot;
    logic [WORD_W-1:0] stored_word;

    // Select the start input for the current direction.
    assign start_sel = shift_right_i ? rend_start_i : lend_start_i;

    ldr_token_ctrl #(
        .WORDS(WORDS), .CASC_CLK(CASC_CLK), .HALT_CLKS(HALT_CLKS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dir_i(shift_right_i), .start_i(start_sel),
        .strb_i(strb_i), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_dir_o(wr_dir),
        .casc_o(casc), .casc_dir_o(casc_dir), .state_o(run_state)
    );

    ldr_word_xform #(.CODE_W(CODE_W), .GROUPS(GROUPS)) u_xform (
        .word_i(data_i), .inv_lo_i(inv_lo_i), .inv_hi_i(inv_hi_i), .word_o(stored_word)
    );

    // Map the word index to a slot: ascending for right shift, descending for left shift.
    assign wr_slot = wr_dir ? wr_idx : (IDX_W'(WORDS - 1) - wr_idx);

    ldr_line_store #(.WORD_W(WORD_W), .WORDS(WORDS)) u_store (
        .clk(clk), .wr_en_i(wr_en), .wr_slot_i(wr_slot), .wr_word_i(stored_word), .line_o(line_o)
    );

    // Route the cascade pulse to the far end of the chain for the run's direction.
    assign lend_start_o = casc & casc_dir;
    assign rend_start_o = casc & ~casc_dir;
endmodule

// File: rtl/line_loader_chk.sv
// Assertion checker for line_loader, attached with bind. Observes the ports and the run state only.
module line_loader_chk
    import line_loader_pkg::*;
#(
    parameter int LINE_W = 2304
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strb_i,
    input logic              rend_start_o,
    input logic              lend_start_o,
    input logic [LINE_W-1:0] line_o,
    input ld_state_e         run_state
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rend_start_o && !lend_start_o));

    // R5
    casc_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rend_start_o || lend_start_o) |=> !(rend_start_o || lend_start_o));

    // R5
    casc_one_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rend_start_o, lend_start_o}));

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == LD_HALT) |=> $stable(line_o));

    // R8
    strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_i) |=> ((run_state == LD_IDLE) && !rend_start_o && !lend_start_o));
endmodule

bind line_loader line_loader_chk #(.LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .strb_i(strb_i), .rend_start_o(rend_start_o),
    .lend_start_o(lend_start_o), .line_o(line_o), .run_state(run_state)
);

// File: tb/test_line_loader.sv
// Scoreboard bench for line_loader. The driver task pushes the expected cascade cycles into a queue,
// and the monitor pops and compares them on each falling edge. Line contents are checked against a bench model.
module test_line_loader;
    localparam int WORDS  = 64;
    localparam int WORD_W = 36;
    localparam int LINE_W = WORD_W * WORDS;

    typedef struct {
        int cyc;
        bit left_pin;
    } casc_ev_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              shift_right_i = 1'b1;
    logic              rend_start_i = 1'b0;
    logic              lend_start_i = 1'b0;
    logic [WORD_W-1:0] data_i = '0;
    logic              inv_lo_i = 1'b0;
    logic              inv_hi_i = 1'b0;
    logic              strb_i = 1'b0;
    logic              rend_start_o;
    logic              lend_start_o;
    logic [LINE_W-1:0] line_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    casc_ev_t exp_q[$];
    logic [LINE_W-1:0] exp_line;

    line_loader i_line_loader (
        .clk(clk), .rst_n(rst_n), .shift_right_i(shift_right_i), .rend_start_i(rend_start_i),
        .rend_start_o(rend_start_o), .lend_start_i(lend_start_i), .lend_start_o(lend_start_o),
        .data_i(data_i), .inv_lo_i(inv_lo_i), .inv_hi_i(inv_hi_i), .strb_i(strb_i), .line_o(line_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [WORD_W-1:0] mkword(int seed, int k);
        logic [WORD_W-1:0] w;
        for (int g = 0; g < 6; g++) w[g*6 +: 6] = 6'(seed + 7*k + 13*g);
        return w;
    endfunction

    // Monitor: compare the cascade outputs with the expected events in the queue.
    always @(negedge clk) begin
        if (rend_start_o || lend_start_o) begin
            checks++;
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc &&
                lend_start_o == exp_q[0].left_pin && rend_start_o == !exp_q[0].left_pin) begin
                void'(exp_q.pop_front());
            end else begin
                fails++;
                $display("FAIL R5 cascade at cycle %0d: got r=%0b l=%0b, expected %0s", cyc,
                         rend_start_o, lend_start_o,
                         (exp_q.size() > 0) ? $sformatf("cycle %0d left=%0b", exp_q[0].cyc, exp_q[0].left_pin) : "none");
            end
        end else if (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            checks++;
            fails++;
            $display("FAIL R5 missing cascade: got none at cycle %0d, expected at cycle %0d", cyc, exp_q[0].cyc);
            void'(exp_q.pop_front());
        end
    end

    task automatic check_line(input string req);
        int bad;
        bad = -1;
        checks++;
        for (int s = WORDS - 1; s >= 0; s--)
            if (line_o[s*WORD_W +: WORD_W] !== exp_line[s*WORD_W +: WORD_W]) bad = s;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s line slot %0d: got %h expected %h", req, bad,
                     line_o[bad*WORD_W +: WORD_W], exp_line[bad*WORD_W +: WORD_W]);
        end
    endtask

    task automatic check_quiet(input string req);
        checks++;
        if (rend_start_o !== 1'b0 || lend_start_o !== 1'b0) begin
            fails++;
            $display("FAIL %s cascade outputs: got r=%0b l=%0b expected 0 0", req, rend_start_o, lend_start_o);
        end
    endtask

    task automatic pulse_strobe();
        strb_i = 1'b1;
        repeat (2) @(negedge clk);
        strb_i = 1'b0;
        @(negedge clk);
    endtask

    // Driver: one line attempt. il: 0/1, or 2 to alternate per word. live=0 means the start is to be ignored.
    // stop_at/rst_at: word index at which a strobe or a reset is applied (>=64 means none).
    task automatic run_line(input bit d, input int il, input bit ih, input int seed, input bit live,
                            input int stop_at, input int rst_at, input int start_len, input int restart_at);
        int cyc0;
        cyc0 = cyc;
        shift_right_i = d;
        if (live && stop_at >= WORDS && rst_at >= WORDS) exp_q.push_back('{cyc0 + 64, d});
        for (int k = 0; k < 70; k++) begin
            logic st, lo;
            logic [WORD_W-1:0] w;
            st = (k < start_len) || (k == restart_at);
            lo = (il == 2) ? k[0] : il[0];
            w = mkword(seed, k);
            if (d) rend_start_i = st; else lend_start_i = st;
            data_i   = w;
            inv_lo_i = lo;
            inv_hi_i = ih;
            strb_i   = (k >= stop_at && k < stop_at + 2);
            rst_n    = (k != rst_at);
            if (live && k < WORDS && k < stop_at && k < rst_at) begin
                int slot;
                slot = d ? k : (WORDS - 1 - k);
                exp_line[slot*WORD_W +: WORD_W] = w ^ {{18{ih}}, {18{lo}}};
            end
            @(negedge clk);
        end
        rend_start_i = 1'b0;
        lend_start_i = 1'b0;
        strb_i = 1'b0;
        rst_n = 1'b1;
        inv_lo_i = 1'b0;
        inv_hi_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1");

        // R3: right shift, plain data
        run_line(1'b1, 0, 1'b0, 3, 1'b1, 99, 99, 1, -1);
        check_line("R3");
        // R6: halted, a new start without strobe is ignored
        run_line(1'b1, 0, 1'b0, 17, 1'b0, 99, 99, 1, -1);
        check_line("R6");
        pulse_strobe();
        // R3: the left-end start pin is not used in right shift
        shift_right_i = 1'b1;
        lend_start_i = 1'b1;
        data_i = mkword(33, 0);
        repeat (3) @(negedge clk);
        lend_start_i = 1'b0;
        repeat (3) @(negedge clk);
        check_line("R3");
        check_quiet("R3");
        // R4 and R7: left shift, low half inverted
        run_line(1'b0, 1, 1'b0, 11, 1'b1, 99, 99, 1, -1);
        check_line("R4");
        pulse_strobe();
        // R2 and R7: start held three clocks, a second pulse mid-run, per-word low inversion, high half inverted
        run_line(1'b1, 2, 1'b1, 20, 1'b1, 99, 99, 3, 20);
        check_line("R2");
        pulse_strobe();
        // R8: strobe in the middle of a line
        run_line(1'b0, 0, 1'b0, 29, 1'b1, 10, 99, 1, -1);
        check_line("R8");
        // R8: the next start is accepted without a further strobe
        run_line(1'b1, 0, 1'b1, 40, 1'b1, 99, 99, 1, -1);
        check_line("R8");
        pulse_strobe();
        // R9: reset in the middle of a line keeps the stored codes
        run_line(1'b1, 1, 1'b1, 50, 1'b1, 99, 30, 1, -1);
        check_line("R9");
        check_quiet("R9");
        // R6/R9: the block is idle after reset, so a left-shift line loads
        run_line(1'b0, 0, 1'b0, 61, 1'b1, 99, 99, 1, -1);
        check_line("R4");
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R5 pending cascades: got %0d left expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule